// File: doc/BRIEF.md
# Indirect Register Access Port

This block is the bus-slave front end of a network controller. Two internal register banks sit behind a handful of I/O offsets: a control/status bank (CSR) and a bus-configuration bank (BCR). Software first writes a register index to a pointer port. It then reads or writes the data port of the bank it wants. Both banks use that one pointer, so a single index write serves an access to either bank.

The window has two layouts. The 16-bit layout is active after a hardware reset. In the 32-bit layout, accesses are doublewords at wider-spaced offsets. A doubleword write of zero to the CSR data port moves the block into 32-bit mode. That mode stays latched until the next hardware reset.

A read of the reset port returns zero and raises a one-cycle `soft_reset` pulse toward the engine. The same read restores both banks to their defaults and clears the pointer. The lowest eight offsets hold a read-only window onto the 6-byte station address.

Top module: `indirect_reg_port`

## Requirements
- R1: After hardware reset, `wide_mode` is 0, `soft_reset` is 0 and `rd_valid` is 0. The pointer reads 0, every CSR register reads 0x0000, and BCR register i reads 0x1000 | i.
- R2: Every read access returns its data on `rd_data`, with `rd_valid` high for exactly the one cycle after the edge that accepted the read. Writes produce no `rd_valid`.
- R3: In 16-bit mode the ports take halfword accesses (`acc_wide`=0) at these offsets: CSR data at 0x10, pointer at 0x12, reset at 0x14, BCR data at 0x16. Data reads are zero-extended to 32 bits.
- R4: In 32-bit mode the ports take doubleword accesses (`acc_wide`=1) at these offsets: CSR data at 0x10, pointer at 0x14, reset at 0x18, BCR data at 0x1C. Writes store `acc_wdata[15:0]`, and reads return the 16-bit register zero-extended.
- R5: Both banks are indexed by the same pointer. Only `acc_wdata[6:0]` of a pointer write is kept, and a pointer read returns those 7 bits zero-extended.
- R6: With the pointer at or beyond a bank's register count (CSR has 16 registers, BCR has 8), a read of that bank returns 0 and a write to it changes nothing.
- R7: A pointer or data access whose width does not match the current mode, or an access to an unused offset, is ignored. When it is a read, it returns 0xFFFFFFFF.
- R8: In 16-bit mode, a doubleword write of 0 to offset 0x10 sets `wide_mode`, visible after that edge. Any other doubleword write there is ignored. Once set, `wide_mode` is cleared only by `rst_n`, never by a soft reset.
- R9: A read of the reset port returns 0. The port is a halfword read at 0x14 or a doubleword read at 0x18, and either works in either mode. At the accepting edge, the read clears the pointer and restores both banks to their defaults. `soft_reset` is high for the next cycle only.
- R10: Reads at offsets 0x00 to 0x07 return the station address in either mode, with byte 0 in the low bits. A doubleword read returns bytes 3..0 at 0x00 and {16'h0, bytes 5..4} at 0x04. Halfword reads at 0x00, 0x02 and 0x04 return bytes 1..0, 3..2 and 5..4, and a halfword read at 0x06 returns 0. Writes there are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = doubleword access, 0 = halfword access |
| acc_offset | input | 5 | Byte offset within the I/O window |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after the read) |
| rd_data | output | 32 | Read data |
| wide_mode | output | 1 | 32-bit I/O layout is active |
| soft_reset | output | 1 | One-cycle soft reset pulse to the engine |

## Verification
The hardest state to reach is 32-bit mode with modified bank contents, followed by a soft reset. Only that combination shows that the soft reset clears the banks and the pointer while leaving the mode latch set. The stimulus first checks that a non-zero doubleword write at the switch offset does not change the mode. It then performs the zero write, fills a CSR through the doubleword ports, and reads the doubleword reset port. Afterwards it confirms the cleared pointer and register, the stuck mode, and the fact that halfword accesses now read all ones.

// File: rtl/irp_pkg.sv
package irp_pkg;

  typedef enum logic [2:0] {
    PK_NONE,
    PK_PROM,
    PK_CSR,
    PK_BCR,
    PK_PTR,
    PK_RST,
    PK_MODE
  } port_e;

  // 16-bit layout
  localparam logic [4:0] N_CSR = 5'h10;
  localparam logic [4:0] N_PTR = 5'h12;
  localparam logic [4:0] N_RST = 5'h14;
  localparam logic [4:0] N_BCR = 5'h16;
  // 32-bit layout
  localparam logic [4:0] W_CSR = 5'h10;
  localparam logic [4:0] W_PTR = 5'h14;
  localparam logic [4:0] W_RST = 5'h18;
  localparam logic [4:0] W_BCR = 5'h1C;

  // Reset value of bank register idx (CSR: zero, BCR: 0x1000 | idx)
  function automatic logic [15:0] bank_default(input bit is_bcr, input int idx);
    logic [15:0] v;
    v = is_bcr ? (16'h1000 | 16'(idx)) : 16'h0000;
    return v;
  endfunction

  // Station address window: sel = offset[2:1]
  function automatic logic [31:0] prom_read(input logic [47:0] sa, input logic wide,
                                            input logic [1:0] sel);
    logic [31:0] v;
    if (wide) v = sel[1] ? {16'h0, sa[47:32]} : sa[31:0];
    else begin
      case (sel)
        2'd0:    v = {16'h0, sa[15:0]};
        2'd1:    v = {16'h0, sa[31:16]};
        2'd2:    v = {16'h0, sa[47:32]};
        default: v = 32'h0;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/irp_decode.sv
module irp_decode
  import irp_pkg::*;
(
  input  logic       wide_mode,
  input  logic       acc_valid,
  input  logic       acc_write,
  input  logic       acc_wide,
  input  logic [4:0] acc_offset,
  input  logic       wdata_zero,
  output port_e      kind
);

  always_comb begin
    kind = PK_NONE;
    if (acc_valid) begin
      if (!acc_write && acc_offset < 5'h08) begin
        kind = PK_PROM;
      end else if (!acc_write && ((!acc_wide && acc_offset == N_RST) ||
                                  (acc_wide && acc_offset == W_RST))) begin
        kind = PK_RST;
      end else if (!wide_mode && acc_wide && acc_write &&
                   acc_offset == N_CSR && wdata_zero) begin
        kind = PK_MODE;
      end else if (!wide_mode && !acc_wide) begin
        case (acc_offset)
          N_CSR:   kind = PK_CSR;
          N_PTR:   kind = PK_PTR;
          N_BCR:   kind = PK_BCR;
          default: kind = PK_NONE;
        endcase
      end else if (wide_mode && acc_wide) begin
        case (acc_offset)
          W_CSR:   kind = PK_CSR;
          W_PTR:   kind = PK_PTR;
          W_BCR:   kind = PK_BCR;
          default: kind = PK_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/irp_bank.sv
module irp_bank
  import irp_pkg::*;
#(
  parameter int REGS   = 16,
  parameter int REG_W  = 16,
  parameter int PTR_W  = 7,
  parameter bit IS_BCR = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] idx,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata
);

  localparam int IDX_W = (REGS > 1) ? $clog2(REGS) : 1;

  logic [REG_W-1:0] regs [REGS];
  logic             hit;

  assign hit = int'(idx) < REGS;

  for (genvar g = 0; g < REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 regs[g] <= REG_W'(bank_default(IS_BCR, g));
      else if (clear)                             regs[g] <= REG_W'(bank_default(IS_BCR, g));
      else if (wr_en && hit && int'(idx) == g)    regs[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) rdata = regs[idx[IDX_W-1:0]];
  end

endmodule

// File: rtl/indirect_reg_port.sv
module indirect_reg_port
  import irp_pkg::*;
#(
  parameter int          CSR_REGS     = 16,
  parameter int          BCR_REGS     = 8,
  parameter int          PTR_W        = 7,
  parameter logic [47:0] STATION_ADDR = 48'h6655_4433_2211
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic        acc_wide,
  input  logic [4:0]  acc_offset,
  input  logic [31:0] acc_wdata,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        wide_mode,
  output logic        soft_reset
);

  localparam int REG_W = 16;

  port_e            kind;
  logic [PTR_W-1:0] ptr_q;
  logic [REG_W-1:0] csr_rdata, bcr_rdata;
  logic             rst_hit, mode_hit, csr_we, bcr_we, ptr_we, rd_acc;
  logic             mode_q, soft_q, rd_valid_q;
  logic [31:0]      rd_data_q, rd_mux;

  irp_decode u_dec (
    .wide_mode (mode_q),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_wide  (acc_wide),
    .acc_offset(acc_offset),
    .wdata_zero(acc_wdata == 32'h0),
    .kind      (kind)
  );

  // Named internal events
  assign rst_hit  = (kind == PK_RST);
  assign mode_hit = (kind == PK_MODE);
  assign csr_we   = (kind == PK_CSR) && acc_write;
  assign bcr_we   = (kind == PK_BCR) && acc_write;
  assign ptr_we   = (kind == PK_PTR) && acc_write;
  assign rd_acc   = acc_valid && !acc_write;

  irp_bank #(.REGS(CSR_REGS), .REG_W(REG_W), .PTR_W(PTR_W), .IS_BCR(1'b0)) u_csr (
    .clk(clk), .rst_n(rst_n), .clear(rst_hit), .wr_en(csr_we),
    .idx(ptr_q), .wdata(acc_wdata[REG_W-1:0]), .rdata(csr_rdata)
  );

  irp_bank #(.REGS(BCR_REGS), .REG_W(REG_W), .PTR_W(PTR_W), .IS_BCR(1'b1)) u_bcr (
    .clk(clk), .rst_n(rst_n), .clear(rst_hit), .wr_en(bcr_we),
    .idx(ptr_q), .wdata(acc_wdata[REG_W-1:0]), .rdata(bcr_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (rst_hit) ptr_q <= '0;
    else if (ptr_we)  ptr_q <= acc_wdata[PTR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= 1'b0;
    else if (mode_hit) mode_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_q <= 1'b0;
    else        soft_q <= rst_hit;
  end

  always_comb begin
    case (kind)
      PK_PROM: rd_mux = prom_read(STATION_ADDR, acc_wide, acc_offset[2:1]);
      PK_CSR:  rd_mux = {{(32-REG_W){1'b0}}, csr_rdata};
      PK_BCR:  rd_mux = {{(32-REG_W){1'b0}}, bcr_rdata};
      PK_PTR:  rd_mux = {{(32-PTR_W){1'b0}}, ptr_q};
      PK_RST:  rd_mux = 32'h0;
      default: rd_mux = 32'hFFFF_FFFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_acc;
      if (rd_acc) rd_data_q <= rd_mux;
    end
  end

  assign rd_valid   = rd_valid_q;
  assign rd_data    = rd_data_q;
  assign wide_mode  = mode_q;
  assign soft_reset = soft_q;

endmodule

// File: rtl/indirect_reg_port_chk.sv
module indirect_reg_port_chk #(
  parameter int PTR_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_write,
  input logic             acc_wide,
  input logic [4:0]       acc_offset,
  input logic [31:0]      acc_wdata,
  input logic             rd_valid,
  input logic             wide_mode,
  input logic             soft_reset,
  input logic             rst_hit,
  input logic [PTR_W-1:0] ptr_q
);

  // R2
  read_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |=> !rd_valid);

  // R8
  mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wide_mode |=> wide_mode);

  // R8
  mode_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_mode && acc_valid && acc_write && acc_wide &&
     acc_offset == 5'h10 && acc_wdata == 32'h0) |=> wide_mode);

  // R9
  soft_pulse_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hit |=> (soft_reset && ptr_q == '0));

  // R9
  soft_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_hit |=> !soft_reset);

endmodule

bind indirect_reg_port indirect_reg_port_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_wide(acc_wide), .acc_offset(acc_offset), .acc_wdata(acc_wdata),
  .rd_valid(rd_valid), .wide_mode(wide_mode), .soft_reset(soft_reset),
  .rst_hit(rst_hit), .ptr_q(ptr_q)
);

// File: tb/test_indirect_reg_port.sv
module test_indirect_reg_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic        acc_wide = 1'b0;
  logic [4:0]  acc_offset = '0;
  logic [31:0] acc_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        wide_mode;
  logic        soft_reset;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;   // 250 MHz

  indirect_reg_port i_indirect_reg_port (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_wide(acc_wide), .acc_offset(acc_offset), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .wide_mode(wide_mode),
    .soft_reset(soft_reset)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read results
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R2: actual=rd_valid=1 expected=no pending read");
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string       t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  // Driver tasks: start and end at a falling edge
  task automatic wr(logic wide, logic [4:0] off, logic [31:0] d);
    acc_valid = 1'b1; acc_write = 1'b1; acc_wide = wide; acc_offset = off; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(logic wide, logic [4:0] off, logic [31:0] exp, string req);
    exp_q.push_back(exp); tag_q.push_back(req);
    acc_valid = 1'b1; acc_write = 1'b0; acc_wide = wide; acc_offset = off; acc_wdata = '0;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic hw_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    hw_reset();
    // R1 reset state
    check("R1", {31'h0, wide_mode}, 32'h0);
    check("R1", {31'h0, soft_reset}, 32'h0);
    check("R1", {31'h0, rd_valid}, 32'h0);
    rd(1'b0, 5'h12, 32'h0, "R1");
    rd(1'b0, 5'h10, 32'h0, "R1");
    rd(1'b0, 5'h16, 32'h0000_1000, "R1");

    // R10 station address window in 16-bit mode
    rd(1'b0, 5'h00, 32'h0000_2211, "R10");
    rd(1'b0, 5'h02, 32'h0000_4433, "R10");
    rd(1'b0, 5'h04, 32'h0000_6655, "R10");
    rd(1'b0, 5'h06, 32'h0000_0000, "R10");
    rd(1'b1, 5'h00, 32'h4433_2211, "R10");
    rd(1'b1, 5'h04, 32'h0000_6655, "R10");
    wr(1'b1, 5'h00, 32'hDEAD_BEEF);
    rd(1'b1, 5'h00, 32'h4433_2211, "R10");

    // R3 16-bit layout, R5 shared pointer
    wr(1'b0, 5'h12, 32'h3);
    wr(1'b0, 5'h10, 32'hBEEF);
    rd(1'b0, 5'h10, 32'h0000_BEEF, "R3");
    rd(1'b0, 5'h12, 32'h3, "R3");
    rd(1'b0, 5'h16, 32'h0000_1003, "R5");
    wr(1'b0, 5'h16, 32'h1234);
    rd(1'b0, 5'h16, 32'h0000_1234, "R5");
    rd(1'b0, 5'h10, 32'h0000_BEEF, "R5");
    wr(1'b0, 5'h12, 32'hFF83);
    rd(1'b0, 5'h12, 32'h3, "R5");
    rd(1'b0, 5'h10, 32'h0000_BEEF, "R5");

    // R6 unimplemented indices
    wr(1'b0, 5'h12, 32'd20);
    rd(1'b0, 5'h10, 32'h0, "R6");
    wr(1'b0, 5'h10, 32'h5555);
    rd(1'b0, 5'h10, 32'h0, "R6");
    wr(1'b0, 5'h12, 32'd10);
    wr(1'b0, 5'h16, 32'h7777);
    rd(1'b0, 5'h16, 32'h0, "R6");

    // R7 width mismatch / unused offsets in 16-bit mode
    wr(1'b0, 5'h12, 32'h3);
    rd(1'b1, 5'h10, 32'hFFFF_FFFF, "R7");
    rd(1'b0, 5'h1A, 32'hFFFF_FFFF, "R7");
    wr(1'b1, 5'h10, 32'h1);
    check("R8", {31'h0, wide_mode}, 32'h0);
    rd(1'b0, 5'h10, 32'h0000_BEEF, "R7");

    // R9 soft reset (halfword read at 0x14)
    rd(1'b0, 5'h14, 32'h0, "R9");
    check("R9", {31'h0, soft_reset}, 32'h1);
    @(negedge clk);
    check("R9", {31'h0, soft_reset}, 32'h0);
    rd(1'b0, 5'h12, 32'h0, "R9");
    wr(1'b0, 5'h12, 32'h3);
    rd(1'b0, 5'h10, 32'h0, "R9");
    rd(1'b0, 5'h16, 32'h0000_1003, "R9");

    // R8 mode switch
    wr(1'b1, 5'h10, 32'h0);
    check("R8", {31'h0, wide_mode}, 32'h1);
    // R7 halfword accesses now ignored
    rd(1'b0, 5'h10, 32'hFFFF_FFFF, "R7");
    wr(1'b0, 5'h12, 32'h9);
    // R4 32-bit layout
    rd(1'b1, 5'h14, 32'h3, "R4");
    wr(1'b1, 5'h14, 32'h5);
    wr(1'b1, 5'h10, 32'h0001_ABCD);
    rd(1'b1, 5'h10, 32'h0000_ABCD, "R4");
    rd(1'b1, 5'h14, 32'h5, "R4");
    rd(1'b1, 5'h1C, 32'h0000_1005, "R4");
    rd(1'b1, 5'h00, 32'h4433_2211, "R10");

    // R9 soft reset via doubleword read at 0x18, mode stays
    rd(1'b1, 5'h18, 32'h0, "R9");
    check("R9", {31'h0, soft_reset}, 32'h1);
    check("R8", {31'h0, wide_mode}, 32'h1);
    @(negedge clk);
    check("R9", {31'h0, soft_reset}, 32'h0);
    rd(1'b1, 5'h14, 32'h0, "R9");
    wr(1'b1, 5'h14, 32'h5);
    rd(1'b1, 5'h10, 32'h0, "R9");
    check("R8", {31'h0, wide_mode}, 32'h1);

    // R8 hardware reset leaves 32-bit mode
    @(negedge clk);
    hw_reset();
    check("R8", {31'h0, wide_mode}, 32'h0);
    rd(1'b0, 5'h12, 32'h0, "R1");
    @(negedge clk);
    check("R2", 32'(exp_q.size()), 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule